// File: doc/BRIEF.md
# NAND Page-Read Command Sequencer

This block starts a page read on a raw NAND flash device. A host pulses a request together with a block number, a page number, a column offset and a flag that selects the spare area. The sequencer then drives the device control pins through the full read set-up. It first waits for the device to report ready. It then issues the read opcode, the column and row address bytes, a short idle gap and the confirm opcode. After a settling delay it waits for ready again, and then pulses done. Moving the page data out of the device is handled elsewhere.

The column is adjusted before it is sent. A spare-area read is issued as an ordinary read whose column is offset by the page size, and on a device with a 16-bit bus the column is counted in words rather than bytes. The row is the page number plus the block number scaled by the pages-per-block parameter. A fifth address byte carries the top row nibble when the device needs one. The write-enable low time, the write-enable high time and the delay before the ready line is trusted are each programmable in clock cycles. All of these settings are captured when a request is accepted.

Top module: `nand_rd_seq`

## Requirements
- R1: The row is `rd_page + rd_blk * PAGES_PER_BLK`. Its bits 7:0 are sent in the third address-phase byte and its bits 15:8 in the fourth.
- R2: With `rd_spare` set, the opcode is still 0x00 and the column sent is `rd_col + PAGE_BYTES`.
- R3: With `cfg_bus16` set, the column (after any spare offset) is shifted right by one bit before it is sent.
- R4: Every transaction begins with one byte 0x00 sent with CLE high. Column bits 7:0 and then column bits 15:8 follow, each with ALE high and CLE low.
- R5: With `cfg_five_cyc` set, a fifth address byte `{4'h0, row[19:16]}` follows row bits 15:8. Without it, exactly four address bytes are sent.
- R6: After the last address byte there is exactly one cycle with CE# low and CLE, ALE, WE# and the data enable all inactive. The byte 0x30 then follows with CLE high.
- R7: After a request is accepted, CE# goes low, and the first WE# low phase starts only in the cycle after a clock edge at which `nand_rb_n` was high.
- R8: After the confirm byte, `max(cfg_twb,1)` cycles pass before `nand_rb_n` is sampled. Done then pulses for one cycle in the cycle after the first edge at which `nand_rb_n` is high, and busy falls in the following cycle.
- R9: Each byte holds WE# low for `max(cfg_we_lo,1)` cycles and then high for `max(cfg_we_hi,1)` cycles. The data and the data enable stay steady across the rising edge of WE#.
- R10: A request seen while busy is high starts nothing and does not change any byte of the transaction in progress.
- R11: During and straight after reset: CE# and WE# are high; CLE, ALE, the data enable, busy and done are low.
- R12: CLE and ALE are never high together. WE# is low only while CE# is low. CE# is high in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request strobe, taken only when idle |
| rd_blk | input | BLK_W | Block number |
| rd_page | input | PAGE_W | Page number within the block |
| rd_col | input | COL_W | Column offset in bytes |
| rd_spare | input | 1 | Read the spare area of the page |
| cfg_bus16 | input | 1 | Device has a 16-bit data bus |
| cfg_five_cyc | input | 1 | Send a fifth address byte |
| cfg_we_lo | input | TW | WE# low time in cycles (0 treated as 1) |
| cfg_we_hi | input | TW | WE# high time in cycles (0 treated as 1) |
| cfg_twb | input | TW | Cycles before ready is sampled after confirm (0 treated as 1) |
| nand_rb_n | input | 1 | Device ready (high) / busy (low) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_dq_out | output | 8 | Command/address byte |
| nand_dq_oe | output | 1 | Drive enable for nand_dq_out |
| seq_busy | output | 1 | Transaction in progress |
| seq_done | output | 1 | One-cycle completion pulse |

## Verification
A plain 8-bit read with a small column and block separates the byte order and the row arithmetic. A spare-area read on the 8-bit bus shows that the page-size offset reaches the column high byte. A 16-bit spare read at the largest block and page, with five cycles, shows that the halving applies after the offset and that the top row nibble is sent. Zero timing settings show the floor of one cycle. Holding the ready line low at request time, and firing a second request mid-transaction, show the initial wait and show that an intruding request changes nothing.

// File: rtl/nand_rd_pkg.sv
`timescale 1ns/1ps
package nand_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDY1,
    ST_WLO,
    ST_WHI,
    ST_GAP,
    ST_TWB,
    ST_RDY2,
    ST_DONE
  } seq_st_e;

  localparam logic [7:0] OP_READ    = 8'h00;
  localparam logic [7:0] OP_CONFIRM = 8'h30;
  localparam int         ROW_BITS   = 20;

  // Column actually sent: spare offset first, then word addressing.
  function automatic logic [15:0] col_calc(input logic [15:0] col,
                                           input logic        spare,
                                           input logic [15:0] page_bytes,
                                           input logic        bus16);
    logic [15:0] c;
    c = col + (spare ? page_bytes : 16'd0);
    return bus16 ? {1'b0, c[15:1]} : c;
  endfunction

  // Row address by multiplication (any pages-per-block value).
  function automatic logic [ROW_BITS-1:0] row_mul(input logic [31:0] blk,
                                                  input logic [31:0] page,
                                                  input logic [31:0] ppb);
    logic [31:0] r;
    r = blk * ppb + page;
    return r[ROW_BITS-1:0];
  endfunction

  // Row address by shift (power-of-two pages-per-block).
  function automatic logic [ROW_BITS-1:0] row_shl(input logic [31:0] blk,
                                                  input logic [31:0] page,
                                                  input int          sh);
    logic [31:0] r;
    r = (blk << sh) + page;
    return r[ROW_BITS-1:0];
  endfunction

endpackage

// File: rtl/nand_rd_addr.sv
`timescale 1ns/1ps
module nand_rd_addr
  import nand_rd_pkg::*;
#(
  parameter int BLK_W         = 14,
  parameter int PAGE_W        = 6,
  parameter int COL_W         = 12,
  parameter int PAGE_BYTES    = 2048,
  parameter int PAGES_PER_BLK = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              spare_i,
  input  logic              bus16_i,
  input  logic              five_i,
  input  logic [2:0]        idx_i,
  input  logic              conf_i,
  output logic [7:0]        byte_o,
  output logic [2:0]        last_idx_o
);
  localparam bool_pow2 = ((PAGES_PER_BLK & (PAGES_PER_BLK - 1)) == 0);
  localparam int  PPB_SH = $clog2(PAGES_PER_BLK);

  logic [ROW_BITS-1:0] row_n;
  logic [ROW_BITS-1:0] row_q;
  logic [15:0]         col_q;
  logic                five_q;

  generate
    if (bool_pow2) begin : g_row_shift
      assign row_n = row_shl(32'(blk_i), 32'(page_i), PPB_SH);
    end else begin : g_row_mult
      assign row_n = row_mul(32'(blk_i), 32'(page_i), 32'(PAGES_PER_BLK));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      five_q <= 1'b0;
    end else if (load) begin
      col_q  <= col_calc(16'(col_i), spare_i, 16'(PAGE_BYTES), bus16_i);
      row_q  <= row_n;
      five_q <= five_i;
    end
  end

  assign last_idx_o = five_q ? 3'd5 : 3'd4;

  always_comb begin
    if (conf_i) begin
      byte_o = OP_CONFIRM;
    end else begin
      case (idx_i)
        3'd0:    byte_o = OP_READ;
        3'd1:    byte_o = col_q[7:0];
        3'd2:    byte_o = col_q[15:8];
        3'd3:    byte_o = row_q[7:0];
        3'd4:    byte_o = row_q[15:8];
        default: byte_o = {4'h0, row_q[19:16]};
      endcase
    end
  end

endmodule

// File: rtl/nand_rd_fsm.sv
`timescale 1ns/1ps
module nand_rd_fsm
  import nand_rd_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [TW-1:0] cfg_lo,
  input  logic [TW-1:0] cfg_hi,
  input  logic [TW-1:0] cfg_twb,
  input  logic          rb_n,
  input  logic [2:0]    last_idx,
  output seq_st_e       st,
  output logic [2:0]    idx,
  output logic          conf,
  output logic          load
);
  localparam logic [TW-1:0] ONE = TW'(1);

  function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  logic [TW-1:0] lo_q, hi_q, twb_q, cnt;

  assign load = (st == ST_IDLE) && req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      idx   <= '0;
      conf  <= 1'b0;
      cnt   <= '0;
      lo_q  <= ONE;
      hi_q  <= ONE;
      twb_q <= ONE;
    end else begin
      case (st)
        ST_IDLE: if (req) begin
          st    <= ST_RDY1;
          lo_q  <= at_least_one(cfg_lo);
          hi_q  <= at_least_one(cfg_hi);
          twb_q <= at_least_one(cfg_twb);
        end
        ST_RDY1: if (rb_n) begin
          st   <= ST_WLO;
          idx  <= '0;
          conf <= 1'b0;
          cnt  <= lo_q - ONE;
        end
        ST_WLO: begin
          if (cnt == '0) begin
            st  <= ST_WHI;
            cnt <= hi_q - ONE;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        ST_WHI: begin
          if (cnt != '0) begin
            cnt <= cnt - ONE;
          end else if (conf) begin
            st  <= ST_TWB;
            cnt <= twb_q - ONE;
          end else if (idx == last_idx) begin
            st <= ST_GAP;
          end else begin
            idx <= idx + 3'd1;
            st  <= ST_WLO;
            cnt <= lo_q - ONE;
          end
        end
        ST_GAP: begin
          st   <= ST_WLO;
          conf <= 1'b1;
          cnt  <= lo_q - ONE;
        end
        ST_TWB: begin
          if (cnt == '0) st <= ST_RDY2;
          else           cnt <= cnt - ONE;
        end
        ST_RDY2: if (rb_n) st <= ST_DONE;
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_rd_seq.sv
`timescale 1ns/1ps
module nand_rd_seq
  import nand_rd_pkg::*;
#(
  parameter int BLK_W         = 14,
  parameter int PAGE_W        = 6,
  parameter int COL_W         = 12,
  parameter int PAGE_BYTES    = 2048,
  parameter int PAGES_PER_BLK = 64,
  parameter int TW            = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [BLK_W-1:0]  rd_blk,
  input  logic [PAGE_W-1:0] rd_page,
  input  logic [COL_W-1:0]  rd_col,
  input  logic              rd_spare,
  input  logic              cfg_bus16,
  input  logic              cfg_five_cyc,
  input  logic [TW-1:0]     cfg_we_lo,
  input  logic [TW-1:0]     cfg_we_hi,
  input  logic [TW-1:0]     cfg_twb,
  input  logic              nand_rb_n,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic [7:0]        nand_dq_out,
  output logic              nand_dq_oe,
  output logic              seq_busy,
  output logic              seq_done
);
  seq_st_e    st;
  logic [2:0] idx;
  logic       conf;
  logic       load;
  logic [2:0] last_idx;
  logic [7:0] byte_val;

  // Named internal events
  logic byte_phase;
  logic cmd_byte;

  nand_rd_fsm #(.TW(TW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (rd_req),
    .cfg_lo   (cfg_we_lo),
    .cfg_hi   (cfg_we_hi),
    .cfg_twb  (cfg_twb),
    .rb_n     (nand_rb_n),
    .last_idx (last_idx),
    .st       (st),
    .idx      (idx),
    .conf     (conf),
    .load     (load)
  );

  nand_rd_addr #(
    .BLK_W         (BLK_W),
    .PAGE_W        (PAGE_W),
    .COL_W         (COL_W),
    .PAGE_BYTES    (PAGE_BYTES),
    .PAGES_PER_BLK (PAGES_PER_BLK)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .blk_i      (rd_blk),
    .page_i     (rd_page),
    .col_i      (rd_col),
    .spare_i    (rd_spare),
    .bus16_i    (cfg_bus16),
    .five_i     (cfg_five_cyc),
    .idx_i      (idx),
    .conf_i     (conf),
    .byte_o     (byte_val),
    .last_idx_o (last_idx)
  );

  assign byte_phase  = (st == ST_WLO) || (st == ST_WHI);
  assign cmd_byte    = conf || (idx == 3'd0);

  assign nand_we_n   = (st != ST_WLO);
  assign nand_cle    = byte_phase && cmd_byte;
  assign nand_ale    = byte_phase && !cmd_byte;
  assign nand_ce_n   = (st == ST_IDLE) || (st == ST_DONE);
  assign nand_dq_oe  = byte_phase;
  assign nand_dq_out = byte_phase ? byte_val : 8'h00;
  assign seq_busy    = (st != ST_IDLE);
  assign seq_done    = (st == ST_DONE);

endmodule

// File: rtl/nand_rd_seq_chk.sv
`timescale 1ns/1ps
module nand_rd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       cle,
  input logic       ale,
  input logic       we_n,
  input logic [7:0] dq,
  input logic       dq_oe,
  input logic       rb_n,
  input logic       busy,
  input logic       done
);

  // R11: idle pin state while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r11_reset_idle: assert (ce_n && we_n && !cle && !ale && !dq_oe && !busy && !done)
        else $error("reset pin state wrong");
    end
  end

  a_r12_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  a_r12_we_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);

  a_r12_ce_high_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ce_n);

  a_r9_dq_held_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> ($stable(dq) && dq_oe));

  a_r7_first_cmd_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(we_n) && cle && dq == 8'h00) |-> $past(rb_n));

  a_r6_gap_before_confirm: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(we_n) && dq == 8'h30) |-> $past(!ce_n && !cle && !ale && we_n && !dq_oe));

  a_r8_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rb_n));

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_busy_falls_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

endmodule

bind nand_rd_seq nand_rd_seq_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ce_n  (nand_ce_n),
  .cle   (nand_cle),
  .ale   (nand_ale),
  .we_n  (nand_we_n),
  .dq    (nand_dq_out),
  .dq_oe (nand_dq_oe),
  .rb_n  (nand_rb_n),
  .busy  (seq_busy),
  .done  (seq_done)
);

// File: tb/nand_rd_seq_tb_top.sv
`timescale 1ns/1ps
module nand_rd_seq_tb_top;
  localparam int PB     = 2048;
  localparam int PPB    = 64;
  localparam int BLK_W  = 14;
  localparam int PAGE_W = 6;
  localparam int COL_W  = 12;
  localparam int TW     = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rd_req = 1'b0;
  logic [BLK_W-1:0]  rd_blk = '0;
  logic [PAGE_W-1:0] rd_page = '0;
  logic [COL_W-1:0]  rd_col = '0;
  logic              rd_spare = 1'b0;
  logic              cfg_bus16 = 1'b0;
  logic              cfg_five_cyc = 1'b0;
  logic [TW-1:0]     cfg_we_lo = '0;
  logic [TW-1:0]     cfg_we_hi = '0;
  logic [TW-1:0]     cfg_twb = '0;
  logic              nand_rb_n;
  logic              nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_dq_oe;
  logic [7:0]        nand_dq_out;
  logic              seq_busy, seq_done;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;

  always #2.5 clk = ~clk;

  // Simple device: goes busy after the confirm byte is latched
  int  busy_left = 0;
  int  dev_busy_len = 0;
  bit  host_hold = 0;
  bit  prev_we = 1;
  bit [9:0] cap_q[$];
  assign nand_rb_n = (busy_left == 0) && !host_hold;

  always @(negedge clk) begin
    if (nand_we_n && !prev_we) begin
      cap_q.push_back({nand_cle, nand_ale, nand_dq_out});
      if (nand_cle && nand_dq_out == 8'h30) busy_left <= dev_busy_len;
      else if (busy_left > 0) busy_left <= busy_left - 1;
    end else if (busy_left > 0) begin
      busy_left <= busy_left - 1;
    end
    prev_we = nand_we_n;
  end

  nand_rd_seq #(
    .BLK_W(BLK_W), .PAGE_W(PAGE_W), .COL_W(COL_W),
    .PAGE_BYTES(PB), .PAGES_PER_BLK(PPB), .TW(TW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_blk(rd_blk),
    .rd_page(rd_page), .rd_col(rd_col), .rd_spare(rd_spare),
    .cfg_bus16(cfg_bus16), .cfg_five_cyc(cfg_five_cyc),
    .cfg_we_lo(cfg_we_lo), .cfg_we_hi(cfg_we_hi), .cfg_twb(cfg_twb),
    .nand_rb_n(nand_rb_n), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .seq_busy(seq_busy), .seq_done(seq_done)
  );

  // ---------------- reference model ----------------
  typedef struct {
    bit       ce_n, cle, ale, we_n, oe, busy, done, wt;
    bit [7:0] dq;
    string    tag;
  } ent_t;

  ent_t     mq[$];
  bit [9:0] exp_cap[$];
  string    exp_tag[$];

  task automatic push_ent(bit ce_n, bit cle, bit ale, bit we_n, bit oe,
                          bit busy, bit done, bit wt, bit [7:0] dq, string tag);
    ent_t e;
    e.ce_n = ce_n; e.cle = cle; e.ale = ale; e.we_n = we_n; e.oe = oe;
    e.busy = busy; e.done = done; e.wt = wt; e.dq = dq; e.tag = tag;
    mq.push_back(e);
  endtask

  task automatic push_byte(int lo, int hi, bit cle, bit ale, int b, string tag);
    repeat (lo) push_ent(0, cle, ale, 0, 1, 1, 0, 0, 8'(b), "R9");
    repeat (hi) push_ent(0, cle, ale, 1, 1, 1, 0, 0, 8'(b), "R9");
    exp_cap.push_back({cle, ale, 8'(b)});
    exp_tag.push_back(tag);
  endtask

  task automatic build_model();
    int c, r, lo, hi, tw;
    int bl[$];
    string ctag;
    c = int'(rd_col) + (rd_spare ? PB : 0);
    if (cfg_bus16) c = c / 2;
    r  = int'(rd_blk) * PPB + int'(rd_page);
    lo = (cfg_we_lo == 0) ? 1 : int'(cfg_we_lo);
    hi = (cfg_we_hi == 0) ? 1 : int'(cfg_we_hi);
    tw = (cfg_twb == 0) ? 1 : int'(cfg_twb);
    ctag = cfg_bus16 ? "R3" : (rd_spare ? "R2" : "R4");
    bl.push_back(c % 256);
    bl.push_back((c / 256) % 256);
    bl.push_back(r % 256);
    bl.push_back((r / 256) % 256);
    if (cfg_five_cyc) bl.push_back((r / 65536) % 16);
    push_ent(0, 0, 0, 1, 0, 1, 0, 1, 8'h00, "R7");
    push_byte(lo, hi, 1, 0, 0, "R4");
    for (int i = 0; i < bl.size(); i++)
      push_byte(lo, hi, 0, 1, bl[i], (i < 2) ? ctag : ((i == 4) ? "R5" : "R1"));
    push_ent(0, 0, 0, 1, 0, 1, 0, 0, 8'h00, "R6");
    push_byte(lo, hi, 1, 0, 8'h30, "R6");
    repeat (tw) push_ent(0, 0, 0, 1, 0, 1, 0, 0, 8'h00, "R8");
    push_ent(0, 0, 0, 1, 0, 1, 0, 1, 8'h00, "R8");
    push_ent(1, 0, 0, 1, 0, 1, 1, 0, 8'h00, "R8");
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
    end else if (mq.size() == 0) begin
      if (rd_req) build_model();
    end else if (!mq[0].wt || nand_rb_n) begin
      void'(mq.pop_front());
    end
  end

  always @(negedge clk) begin
    ent_t e;
    if (rst_n && !finished) begin
      if (mq.size() != 0) begin
        e = mq[0];
      end else begin
        e.ce_n = 1; e.cle = 0; e.ale = 0; e.we_n = 1; e.oe = 0;
        e.busy = 0; e.done = 0; e.wt = 0; e.dq = 8'h00; e.tag = "R10";
      end
      n_chk++;
      if (nand_ce_n !== e.ce_n || nand_cle !== e.cle || nand_ale !== e.ale ||
          nand_we_n !== e.we_n || nand_dq_oe !== e.oe || nand_dq_out !== e.dq ||
          seq_busy !== e.busy || seq_done !== e.done) begin
        n_bad++;
        $display("FAIL %s t=%0t pins ce_n/cle/ale/we_n/oe/dq/busy/done actual=%b%b%b%b%b/%h/%b%b expected=%b%b%b%b%b/%h/%b%b",
                 e.tag, $time, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_dq_oe,
                 nand_dq_out, seq_busy, seq_done, e.ce_n, e.cle, e.ale, e.we_n,
                 e.oe, e.dq, e.busy, e.done);
      end
      n_chk++;
      if (nand_cle && nand_ale) begin
        n_bad++;
        $display("FAIL R12 cle/ale both high actual=11 expected=not 11");
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic check_caps();
    n_chk++;
    if (cap_q.size() != exp_cap.size()) begin
      n_bad++;
      $display("FAIL R5 latched byte count actual=%0d expected=%0d",
               cap_q.size(), exp_cap.size());
    end else begin
      for (int i = 0; i < exp_cap.size(); i++) begin
        n_chk++;
        if (cap_q[i] !== exp_cap[i]) begin
          n_bad++;
          $display("FAIL %s latched byte %0d {cle,ale,dq} actual=%h expected=%h",
                   exp_tag[i], i, cap_q[i], exp_cap[i]);
        end
      end
    end
    cap_q.delete();
    exp_cap.delete();
    exp_tag.delete();
  endtask

  task automatic do_read(int blk, int page, int col, bit sp, bit b16, bit five,
                         int lo, int hi, int twb, int dbusy, int hold, bit intrude);
    int guard;
    @(negedge clk); #1;
    dev_busy_len = dbusy;
    host_hold    = (hold > 0);
    rd_blk = BLK_W'(blk); rd_page = PAGE_W'(page); rd_col = COL_W'(col);
    rd_spare = sp; cfg_bus16 = b16; cfg_five_cyc = five;
    cfg_we_lo = TW'(lo); cfg_we_hi = TW'(hi); cfg_twb = TW'(twb);
    rd_req = 1;
    @(negedge clk); #1;
    rd_req = 0;
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      #1 host_hold = 0;
    end
    if (intrude) begin
      // R10: second request mid-transaction with different fields
      repeat (4) @(negedge clk);
      #1;
      rd_blk = BLK_W'(7); rd_page = PAGE_W'(1); rd_col = COL_W'(5);
      rd_spare = ~sp; cfg_five_cyc = ~five;
      rd_req = 1;
      @(negedge clk); #1;
      rd_req = 0;
    end
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while ((seq_busy || mq.size() != 0) && guard < 2000);
    #1;
    check_caps();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    n_chk++;
    if (!(nand_ce_n && nand_we_n && !nand_cle && !nand_ale && !nand_dq_oe &&
          !seq_busy && !seq_done)) begin
      n_bad++;
      $display("FAIL R11 reset pins ce_n/we_n/cle/ale/oe/busy/done actual=%b%b%b%b%b%b%b expected=1100000",
               nand_ce_n, nand_we_n, nand_cle, nand_ale, nand_dq_oe, seq_busy, seq_done);
    end
    #1 rst_n = 1;
    repeat (2) @(negedge clk);

    // R4 R1: plain 8-bit read, shortest timing
    do_read(5, 3, 'h1A4, 0, 0, 0, 1, 1, 1, 6, 0, 0);
    // R2: spare read on 8-bit bus, longer WE# and tWB
    do_read(100, 63, 'h010, 1, 0, 0, 3, 2, 4, 3, 0, 0);
    // R3 R5: 16-bit spare read at top block/page with five cycles
    do_read(16383, 63, 'hFFF, 1, 1, 1, 2, 1, 2, 5, 0, 0);
    // R9: zero timing values act as one cycle
    do_read('h2A5B, 17, 'h7FE, 0, 1, 1, 0, 0, 0, 2, 0, 0);
    // R7: device still busy when the request arrives
    do_read(9, 40, 'h123, 0, 0, 0, 2, 2, 1, 4, 8, 0);
    // R10: request fired while busy is ignored
    do_read(300, 12, 'h0AB, 0, 0, 1, 2, 2, 2, 6, 0, 1);
    // R8: device never goes busy after confirm
    do_read(1, 1, 'h001, 1, 1, 0, 1, 3, 3, 0, 0, 0);

    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R8 watchdog expired: busy actual=%b expected=0", seq_busy);
      finish_run();
    end
  end

endmodule